// File: doc/BRIEF.md
# Video Port Byte Bridge

This block sits between an 8-bit CPU and the 16-bit register ports of a video controller, inside one banked address window. It looks only at the low address byte of each access, and it checks that the region bits above that byte are zero. It then sorts the access into one of three outcomes. The access is forwarded to a port, dropped without effect, or treated as illegal. An illegal access sets a sticky lockup flag, and the CPU side uses that flag to stall its bus.

On a write the 8-bit value is copied into both halves of a 16-bit word. That word is sent to the data, control or test port, or the raw byte is sent to a sound generator. On a read the block selects one byte lane of a 16-bit value supplied by the video side: the data port, the control/status port or the beam counter. The lane follows the address parity. The result is registered and appears one clock after the read request. The video controller and the sound generator are outside this block.

Top module: `vport_byte_bridge`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `lockup_out`, `rvalid_out`, every write strobe, `vid_wdata` and `snd_wdata` are zero.
- R2: An access is legal only when address bits 18:16 are all zero. Any other value is illegal whatever the low byte is. Such an access produces no port strobe, and a read of it returns 0xFF.
- R3: A write at low byte 0x00–0x03 pulses `vid_data_wr` for one cycle, one clock after `cpu_wr`. In that cycle `vid_wdata` holds the byte in both halves. Address bits 15:8 do not affect decoding.
- R4: A write at 0x04–0x07 pulses `vid_ctrl_wr`, and a write at 0x1C–0x1F pulses `vid_test_wr`. Both have the same timing and the same duplicated word as R3.
- R5: A write at an odd offset 0x11, 0x13, 0x15 or 0x17 pulses `snd_wr` one clock later, with `snd_wdata` equal to the byte. No access ever pulses more than one write strobe.
- R6: A write at an even offset 0x10–0x16, or at 0x18–0x1B, pulses no strobe, sets no lockup and leaves `vid_wdata` and `snd_wdata` unchanged.
- R7: A read at 0x00–0x03 pulses `vid_data_rd` in the request cycle. One clock later `rvalid_out` is high for one cycle and `rdata_out` is `vid_data_in[15:8]` for an even offset and `vid_data_in[7:0]` for an odd offset.
- R8: A read at 0x04–0x07 pulses `vid_ctrl_rd`. The result is 0xFC OR `vid_status_in[9:8]` for an even offset and `vid_status_in[7:0]` for an odd offset.
- R9: A read at 0x08–0x0F pulses `vid_beam_rd`. The result is `vid_beam_in[15:8]` for an even offset and `vid_beam_in[7:0]` for an odd offset.
- R10: A read at 0x18–0x1F returns 0xFF without lockup. A read at 0x10–0x17 or 0x20–0xFF returns 0xFF and is illegal. A write at 0x08–0x0F or 0x20–0xFF is illegal.
- R11: An illegal access sets `lockup_out` one clock later only when `force_ack` is low. With `force_ack` high the access is still dropped or answered with 0xFF, but the flag stays clear.
- R12: Once set, `lockup_out` stays high until reset. While it is high, every access is ignored: no strobe and no `rvalid_out`.
- R13: If `cpu_wr` and `cpu_rd` are high in the same cycle, the write is performed and the read is dropped, so no `rvalid_out` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 19 | CPU address inside the banked window |
| cpu_wr | input | 1 | Single-cycle write request |
| cpu_rd | input | 1 | Single-cycle read request |
| cpu_wdata | input | 8 | Write byte |
| force_ack | input | 1 | When high, illegal accesses do not set lockup |
| rdata_out | output | 8 | Registered read result |
| rvalid_out | output | 1 | Read result valid, one cycle |
| lockup_out | output | 1 | Sticky lockup flag (stall request) |
| vid_data_wr | output | 1 | Data port write strobe |
| vid_ctrl_wr | output | 1 | Control port write strobe |
| vid_test_wr | output | 1 | Test register write strobe |
| vid_wdata | output | 16 | Duplicated write word for the video ports |
| snd_wr | output | 1 | Sound generator write strobe |
| snd_wdata | output | 8 | Sound generator write byte |
| vid_data_rd | output | 1 | Data port read strobe, request cycle |
| vid_ctrl_rd | output | 1 | Control port read strobe, request cycle |
| vid_beam_rd | output | 1 | Beam counter read strobe, request cycle |
| vid_data_in | input | 16 | Data port read value |
| vid_status_in | input | 16 | Control/status read value |
| vid_beam_in | input | 16 | Beam counter read value |

## Verification
Writes are sent to each port range with distinct bytes, and the bench checks that the right strobe fires and that the word is duplicated. An address with bits 15:8 set shows that only the low byte is decoded. Reads from the three sources use 16-bit values with different high and low bytes and distinct status bits 9:8. This tells even-lane selection from odd-lane selection and shows the 0xFC fill. A sweep of the ignored write offsets, the illegal offsets with `force_ack` high and low, a bad region, a simultaneous write and read, and accesses made after lockup separates the forward, ignore and lockup outcomes.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
  typedef enum logic [2:0] {
    PC_DATA,
    PC_CTRL,
    PC_BEAM,
    PC_TEST,
    PC_SOUND,
    PC_QUIET,
    PC_TRAP
  } port_cls_e;

  localparam int OFF_W = 8;
endpackage

// File: rtl/vpb_decode.sv
module vpb_decode
  import vpb_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int REGION_LO = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output port_cls_e         wr_cls,
  output port_cls_e         rd_cls,
  output logic              lane_lo
);
  logic [OFF_W-1:0] off;
  logic             region_ok;

  assign off       = addr[OFF_W-1:0];
  assign region_ok = (addr[ADDR_W-1:REGION_LO] == '0);
  assign lane_lo   = off[0];

  // offsets 0x00-0x1F split into 4-byte groups by off[4:2]
  always_comb begin
    wr_cls = PC_TRAP;
    if (region_ok && off[7:5] == 3'b000) begin
      case (off[4:2])
        3'b000:         wr_cls = PC_DATA;
        3'b001:         wr_cls = PC_CTRL;
        3'b100, 3'b101: wr_cls = off[0] ? PC_SOUND : PC_QUIET;
        3'b110:         wr_cls = PC_QUIET;
        3'b111:         wr_cls = PC_TEST;
        default:        wr_cls = PC_TRAP;
      endcase
    end
  end

  always_comb begin
    rd_cls = PC_TRAP;
    if (region_ok && off[7:5] == 3'b000) begin
      case (off[4:2])
        3'b000:         rd_cls = PC_DATA;
        3'b001:         rd_cls = PC_CTRL;
        3'b010, 3'b011: rd_cls = PC_BEAM;
        3'b110, 3'b111: rd_cls = PC_QUIET;
        default:        rd_cls = PC_TRAP;
      endcase
    end
  end
endmodule

// File: rtl/vpb_wr_path.sv
module vpb_wr_path
  import vpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  port_cls_e               cls,
  input  logic [BYTE_W-1:0]       wdata,
  output logic                    data_wr,
  output logic                    ctrl_wr,
  output logic                    test_wr,
  output logic [LANES*BYTE_W-1:0] port_wdata,
  output logic                    snd_wr,
  output logic [BYTE_W-1:0]       snd_wdata
);
  logic [LANES*BYTE_W-1:0] dup;
  logic                    to_video;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dup[g*BYTE_W +: BYTE_W] = wdata;
  end

  assign to_video = (cls == PC_DATA) || (cls == PC_CTRL) || (cls == PC_TEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_wr    <= 1'b0;
      ctrl_wr    <= 1'b0;
      test_wr    <= 1'b0;
      snd_wr     <= 1'b0;
      port_wdata <= '0;
      snd_wdata  <= '0;
    end else begin
      data_wr <= accept && (cls == PC_DATA);
      ctrl_wr <= accept && (cls == PC_CTRL);
      test_wr <= accept && (cls == PC_TEST);
      snd_wr  <= accept && (cls == PC_SOUND);
      if (accept && to_video)         port_wdata <= dup;
      if (accept && cls == PC_SOUND)  snd_wdata  <= wdata;
    end
  end
endmodule

// File: rtl/vpb_rd_path.sv
module vpb_rd_path
  import vpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  port_cls_e         cls,
  input  logic              lane_lo,
  input  logic [PORT_W-1:0] data_in,
  input  logic [PORT_W-1:0] status_in,
  input  logic [PORT_W-1:0] beam_in,
  output logic              data_rd,
  output logic              ctrl_rd,
  output logic              beam_rd,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid
);
  localparam int FILL_W = BYTE_W - 2;

  logic [BYTE_W-1:0] sel;

  function automatic logic [BYTE_W-1:0] pick(input logic [PORT_W-1:0] w, input logic lo);
    return lo ? w[BYTE_W-1:0] : w[PORT_W-1 -: BYTE_W];
  endfunction

  assign data_rd = accept && (cls == PC_DATA);
  assign ctrl_rd = accept && (cls == PC_CTRL);
  assign beam_rd = accept && (cls == PC_BEAM);

  always_comb begin
    case (cls)
      PC_DATA: sel = pick(data_in, lane_lo);
      PC_CTRL: sel = lane_lo ? status_in[BYTE_W-1:0]
                             : {{FILL_W{1'b1}}, status_in[BYTE_W+1:BYTE_W]};
      PC_BEAM: sel = pick(beam_in, lane_lo);
      default: sel = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= accept;
      if (accept) rdata <= sel;
    end
  end
endmodule

// File: rtl/vpb_lock.sv
module vpb_lock (
  input  logic clk,
  input  logic rst,
  input  logic trap,
  input  logic force_ack,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else if (trap && !force_ack) locked <= 1'b1;
  end
endmodule

// File: rtl/vport_byte_bridge.sv
module vport_byte_bridge
  import vpb_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int REGION_LO = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic                  cpu_wr,
  input  logic                  cpu_rd,
  input  logic [BYTE_W-1:0]     cpu_wdata,
  input  logic                  force_ack,
  output logic [BYTE_W-1:0]     rdata_out,
  output logic                  rvalid_out,
  output logic                  lockup_out,
  output logic                  vid_data_wr,
  output logic                  vid_ctrl_wr,
  output logic                  vid_test_wr,
  output logic [2*BYTE_W-1:0]   vid_wdata,
  output logic                  snd_wr,
  output logic [BYTE_W-1:0]     snd_wdata,
  output logic                  vid_data_rd,
  output logic                  vid_ctrl_rd,
  output logic                  vid_beam_rd,
  input  logic [2*BYTE_W-1:0]   vid_data_in,
  input  logic [2*BYTE_W-1:0]   vid_status_in,
  input  logic [2*BYTE_W-1:0]   vid_beam_in
);
  localparam int LANES  = 2;
  localparam int PORT_W = LANES * BYTE_W;

  port_cls_e wr_cls, rd_cls;
  logic      lane_lo;
  logic      accept_wr, accept_rd, trap;

  assign accept_wr = cpu_wr && !lockup_out;
  assign accept_rd = cpu_rd && !cpu_wr && !lockup_out;   // R13 write wins
  assign trap      = (accept_wr && wr_cls == PC_TRAP) ||
                     (accept_rd && rd_cls == PC_TRAP);

  vpb_decode #(.ADDR_W(ADDR_W), .REGION_LO(REGION_LO)) u_decode (
    .addr    (cpu_addr),
    .wr_cls  (wr_cls),
    .rd_cls  (rd_cls),
    .lane_lo (lane_lo)
  );

  vpb_wr_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept_wr),
    .cls        (wr_cls),
    .wdata      (cpu_wdata),
    .data_wr    (vid_data_wr),
    .ctrl_wr    (vid_ctrl_wr),
    .test_wr    (vid_test_wr),
    .port_wdata (vid_wdata),
    .snd_wr     (snd_wr),
    .snd_wdata  (snd_wdata)
  );

  vpb_rd_path #(.BYTE_W(BYTE_W), .PORT_W(PORT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept_rd),
    .cls       (rd_cls),
    .lane_lo   (lane_lo),
    .data_in   (vid_data_in),
    .status_in (vid_status_in),
    .beam_in   (vid_beam_in),
    .data_rd   (vid_data_rd),
    .ctrl_rd   (vid_ctrl_rd),
    .beam_rd   (vid_beam_rd),
    .rdata     (rdata_out),
    .rvalid    (rvalid_out)
  );

  vpb_lock u_lock (
    .clk       (clk),
    .rst       (rst),
    .trap      (trap),
    .force_ack (force_ack),
    .locked    (lockup_out)
  );
endmodule

// File: rtl/vport_byte_bridge_chk.sv
module vport_byte_bridge_chk #(
  parameter int ADDR_W    = 19,
  parameter int REGION_LO = 16,
  parameter int BYTE_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                cpu_wr,
  input logic                cpu_rd,
  input logic [BYTE_W-1:0]   cpu_wdata,
  input logic                force_ack,
  input logic [BYTE_W-1:0]   rdata_out,
  input logic                rvalid_out,
  input logic                lockup_out,
  input logic                vid_data_wr,
  input logic                vid_ctrl_wr,
  input logic                vid_test_wr,
  input logic [2*BYTE_W-1:0] vid_wdata,
  input logic                snd_wr,
  input logic                vid_data_rd,
  input logic                vid_ctrl_rd,
  input logic                vid_beam_rd
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!lockup_out && !rvalid_out && !vid_data_wr && !snd_wr));

  a_r2_bad_region_locks: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !lockup_out && !force_ack && cpu_addr[ADDR_W-1:REGION_LO] != '0)
      |=> lockup_out);

  a_r3_data_write_follows: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !lockup_out && cpu_addr[ADDR_W-1:REGION_LO] == '0 && cpu_addr[7:0] <= 8'h03)
      |=> (vid_data_wr && vid_wdata[BYTE_W-1:0] == $past(cpu_wdata)));

  a_r4_halves_match: assert property (@(posedge clk) disable iff (rst)
    (vid_data_wr || vid_ctrl_wr || vid_test_wr)
      |-> (vid_wdata[2*BYTE_W-1:BYTE_W] == vid_wdata[BYTE_W-1:0]));

  a_r5_single_write_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vid_data_wr, vid_ctrl_wr, vid_test_wr, snd_wr}));

  a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && !lockup_out) |=> rvalid_out);

  a_r7_no_rvalid_without_read: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> !rvalid_out);

  a_r8_ctrl_even_fill: assert property (@(posedge clk) disable iff (rst)
    (vid_ctrl_rd && !cpu_addr[0]) |=> (rdata_out[BYTE_W-1:2] == '1));

  a_r11_forced_no_lock: assert property (@(posedge clk) disable iff (rst)
    (force_ack && !lockup_out) |=> !lockup_out);

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lockup_out |=> lockup_out);

  a_r12_no_read_strobe_locked: assert property (@(posedge clk) disable iff (rst)
    lockup_out |-> !(vid_data_rd || vid_ctrl_rd || vid_beam_rd));

  a_r12_no_rvalid_locked: assert property (@(posedge clk) disable iff (rst)
    lockup_out |=> !rvalid_out);

  a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_rd) |=> !rvalid_out);
endmodule

bind vport_byte_bridge vport_byte_bridge_chk #(
  .ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .force_ack(force_ack), .rdata_out(rdata_out),
  .rvalid_out(rvalid_out), .lockup_out(lockup_out), .vid_data_wr(vid_data_wr),
  .vid_ctrl_wr(vid_ctrl_wr), .vid_test_wr(vid_test_wr), .vid_wdata(vid_wdata),
  .snd_wr(snd_wr), .vid_data_rd(vid_data_rd), .vid_ctrl_rd(vid_ctrl_rd),
  .vid_beam_rd(vid_beam_rd)
);

// File: tb/vport_byte_bridge_bench.sv
`timescale 1ns/1ps
module vport_byte_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, force_ack = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rdata_out, snd_wdata;
  logic        rvalid_out, lockup_out, vid_data_wr, vid_ctrl_wr, vid_test_wr, snd_wr;
  logic        vid_data_rd, vid_ctrl_rd, vid_beam_rd;
  logic [15:0] vid_wdata;
  logic [15:0] vid_data_in = 16'h3C5A, vid_status_in = 16'h0281, vid_beam_in = 16'h7E19;

  int checks = 0, failures = 0;
  bit done = 0;
  logic rs_data, rs_ctrl, rs_beam;
  logic [15:0] stub_data, stub_ctrl, stub_test;
  logic [7:0]  stub_snd;

  always #5 clk = ~clk;

  vport_byte_bridge u_vport_byte_bridge (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .force_ack(force_ack), .rdata_out(rdata_out),
    .rvalid_out(rvalid_out), .lockup_out(lockup_out), .vid_data_wr(vid_data_wr),
    .vid_ctrl_wr(vid_ctrl_wr), .vid_test_wr(vid_test_wr), .vid_wdata(vid_wdata),
    .snd_wr(snd_wr), .snd_wdata(snd_wdata), .vid_data_rd(vid_data_rd),
    .vid_ctrl_rd(vid_ctrl_rd), .vid_beam_rd(vid_beam_rd), .vid_data_in(vid_data_in),
    .vid_status_in(vid_status_in), .vid_beam_in(vid_beam_in)
  );

  // register stubs for the video and sound sides
  always_ff @(posedge clk) begin
    if (rst) begin
      stub_data <= '0; stub_ctrl <= '0; stub_test <= '0; stub_snd <= '0;
    end else begin
      if (vid_data_wr) stub_data <= vid_wdata;
      if (vid_ctrl_wr) stub_ctrl <= vid_wdata;
      if (vid_test_wr) stub_test <= vid_wdata;
      if (snd_wr)      stub_snd  <= snd_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one access; returns at the negedge where registered outputs show its result
  task automatic access(input bit w, input bit r, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_rd = r; cpu_wdata = d;
    #1;
    rs_data = vid_data_rd; rs_ctrl = vid_ctrl_rd; rs_beam = vid_beam_rd;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  function automatic logic [3:0] wstrobes();
    return {vid_data_wr, vid_ctrl_wr, vid_test_wr, snd_wr};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "lockup", lockup_out, 0);
    chk("R1", "rvalid", rvalid_out, 0);
    chk("R1", "wstrobes", wstrobes(), 0);
    chk("R1", "vid_wdata", vid_wdata, 0);
    chk("R1", "snd_wdata", snd_wdata, 0);
  endtask

  task automatic t_writes();
    access(1, 0, 19'h00002, 8'hA5);
    chk("R3", "data strobe", wstrobes(), 4'b1000);
    chk("R3", "data word", vid_wdata, 16'hA5A5);
    access(1, 0, 19'h0AB01, 8'h3E);
    chk("R3", "high addr byte ignored", wstrobes(), 4'b1000);
    @(negedge clk);
    chk("R3", "strobe one cycle", wstrobes(), 0);
    chk("R3", "stub data", stub_data, 16'h3E3E);
    access(1, 0, 19'h00006, 8'h81);
    chk("R4", "ctrl strobe", wstrobes(), 4'b0100);
    chk("R4", "ctrl word", vid_wdata, 16'h8181);
    access(1, 0, 19'h0001D, 8'h42);
    chk("R4", "test strobe", wstrobes(), 4'b0010);
    chk("R4", "test word", vid_wdata, 16'h4242);
    access(1, 0, 19'h00015, 8'h9F);
    chk("R5", "sound strobe", wstrobes(), 4'b0001);
    chk("R5", "sound byte", snd_wdata, 8'h9F);
  endtask

  task automatic t_ignored();
    logic [7:0] offs [8] = '{8'h10, 8'h12, 8'h14, 8'h16, 8'h18, 8'h19, 8'h1A, 8'h1B};
    for (int i = 0; i < 8; i++) begin
      access(1, 0, {11'h0, offs[i]}, 8'h5C);
      chk("R6", $sformatf("no strobe @%0h", offs[i]), wstrobes(), 0);
      chk("R6", $sformatf("no lock @%0h", offs[i]), lockup_out, 0);
    end
    chk("R6", "vid_wdata kept", vid_wdata, 16'h4242);
    chk("R6", "snd_wdata kept", snd_wdata, 8'h9F);
  endtask

  task automatic t_reads();
    access(0, 1, 19'h00000, 0);
    chk("R7", "data rd strobe", rs_data, 1);
    chk("R7", "rvalid", rvalid_out, 1);
    chk("R7", "even lane", rdata_out, 8'h3C);
    access(0, 1, 19'h00003, 0);
    chk("R7", "odd lane", rdata_out, 8'h5A);
    @(negedge clk);
    chk("R7", "rvalid one cycle", rvalid_out, 0);
    access(0, 1, 19'h00004, 0);
    chk("R8", "ctrl rd strobe", rs_ctrl, 1);
    chk("R8", "ctrl even", rdata_out, 8'hFE);
    access(0, 1, 19'h00007, 0);
    chk("R8", "ctrl odd", rdata_out, 8'h81);
    access(0, 1, 19'h0000A, 0);
    chk("R9", "beam rd strobe", rs_beam, 1);
    chk("R9", "beam even", rdata_out, 8'h7E);
    access(0, 1, 19'h0000F, 0);
    chk("R9", "beam odd", rdata_out, 8'h19);
  endtask

  task automatic t_quiet_reads();
    for (int o = 8'h18; o <= 8'h1F; o++) begin
      access(0, 1, 19'(o), 0);
      chk("R10", $sformatf("quiet read @%0h", o), {rvalid_out, rdata_out}, 9'h1FF);
      chk("R10", $sformatf("quiet no lock @%0h", o), lockup_out, 0);
    end
  endtask

  task automatic t_both();
    access(1, 1, 19'h00001, 8'h77);
    chk("R13", "write done", wstrobes(), 4'b1000);
    chk("R13", "read dropped", rvalid_out, 0);
  endtask

  task automatic t_forced();
    force_ack = 1'b1;
    access(0, 1, 19'h00020, 0);
    chk("R11", "forced read ff", {rvalid_out, rdata_out}, 9'h1FF);
    chk("R11", "forced read no lock", lockup_out, 0);
    access(1, 0, 19'h00009, 8'h11);
    chk("R11", "forced write no strobe", wstrobes(), 0);
    chk("R11", "forced write no lock", lockup_out, 0);
    access(1, 0, 19'h20000, 8'h11);
    chk("R11", "forced region no lock", lockup_out, 0);
    force_ack = 1'b0;
  endtask

  task automatic t_lockup();
    access(1, 0, 19'h00008, 8'h22);
    chk("R10", "write 08 locks", lockup_out, 1);
    chk("R10", "write 08 no strobe", wstrobes(), 0);
    access(1, 0, 19'h00000, 8'h33);
    chk("R12", "locked write dropped", wstrobes(), 0);
    access(0, 1, 19'h00001, 0);
    chk("R12", "locked read no strobe", rs_data, 0);
    chk("R12", "locked read no rvalid", rvalid_out, 0);
    repeat (5) @(negedge clk);
    chk("R12", "lock sticky", lockup_out, 1);
    chk("R12", "stub untouched", stub_data, 16'h7777);
    do_reset();
    chk("R12", "reset clears lock", lockup_out, 0);
  endtask

  task automatic t_region();
    access(1, 0, 19'h10004, 8'h44);
    chk("R2", "bad region no strobe", wstrobes(), 0);
    chk("R2", "bad region locks", lockup_out, 1);
    do_reset();
    access(0, 1, 19'h70001, 0);
    chk("R2", "bad region read strobe", rs_data, 0);
    chk("R2", "bad region read ff", {rvalid_out, rdata_out}, 9'h1FF);
    chk("R2", "bad region read locks", lockup_out, 1);
    do_reset();
    access(0, 1, 19'h00012, 0);
    chk("R10", "read 12 ff", {rvalid_out, rdata_out}, 9'h1FF);
    chk("R10", "read 12 locks", lockup_out, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_writes();
    t_ignored();
    t_reads();
    t_quiet_reads();
    t_both();
    t_forced();
    t_lockup();
    t_region();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule